// File: doc/BRIEF.md
# SPI DAC Waveform Player

This block plays a stored waveform through a serial DAC. A 256-entry sample table is read at a table address that moves forward by a programmable step after every transfer. A free-running rate timer issues a transfer trigger every `rate_period` clocks, and that trigger sets the DAC update rate. The step acts as a phase increment: a larger step covers the table in fewer transfers and so raises the output frequency.

Each transfer sends one 16-bit frame on a chip-select, serial-clock and serial-data triple. The frame carries the 12-bit sample behind four zero bits. The serializer is paced by a one-cycle tick that fires every 5 system clocks. A full frame therefore lasts 160 clocks, which can be longer than the trigger period. A trigger that arrives during a frame is dropped, and the drop is reported on the `overrun` pulse. The serial output has no back-pressure: the DAC always takes the frame at the pace the block sets. All control pins are plain levels.

Top module: `wave_dac_player`

## Requirements
- R1: While `rst` is high at a clock edge, the table address and the rate counter are cleared, `dac_cs_n` is 1, and `dac_sclk`, `dac_sdo`, `busy` and `overrun` are 0.
- R2: With `en` high and `rate_period` = P (P >= 1), a trigger fires on every P-th clock. The first frame's `dac_cs_n` falls P clocks after `en` rises from a cleared counter. While `en` is low the counter is held at 0 and no frame starts.
- R3: A frame is 16 bits, MSB first: four 0 bits, then the 12-bit sample. `dac_cs_n` is low for exactly 160 clocks per frame.
- R4: `dac_sclk` is low whenever `dac_cs_n` is high. Within a frame each half period of `dac_sclk` is 5 clocks, with 16 rising edges per frame. `dac_sdo` changes only on a falling `dac_sclk` edge, so a receiver samples it on the rising edge.
- R5: Table entry i (i = 0..255) holds the 12-bit value {i[7:0], i[7:4]}.
- R6: Each frame carries exactly one table entry, read at its start. The first frame after reset reads entry 0, and every later frame reads the previous address plus the step.
- R7: Address arithmetic is modulo 256, so the address wraps to the table start once it passes 255.
- R8: `step` is captured when a frame starts. A change while a frame is in flight affects only the address used after the next frame start.
- R9: A trigger that arrives while `busy` is high starts nothing and produces a one-clock `overrun` pulse on the next cycle. A frame in flight is never restarted.
- R10: `busy` rises in the cycle in which `dac_cs_n` falls and stays high until the frame's last falling `dac_sclk` edge, when `dac_cs_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Runs the rate timer; low holds it cleared |
| step | input | 8 | Table address increment per transfer |
| rate_period | input | 16 | Trigger period in clocks |
| dac_cs_n | output | 1 | DAC chip select, active low |
| dac_sclk | output | 1 | DAC serial clock |
| dac_sdo | output | 1 | DAC serial data, MSB first |
| busy | output | 1 | A frame is in progress |
| overrun | output | 1 | One-clock pulse when a trigger was dropped |

## Verification
The bench uses a trigger period of 100, shorter than the 160-clock frame. If the design accepted a trigger mid-frame, it would restart or truncate the frame and the scoreboard would see short or corrupted words. A step of 200 forces address wrap, so a design that saturated at 255 or kept a ninth address bit would read the wrong entries. The step is changed in the middle of a frame. A design that did not capture the step at frame start would move to the new spacing one sample early. The bench also measures the first-frame latency, the 5-clock half periods and the 160-clock select window. These catch an off-by-one in the rate counter, a serial clock enable that is held high as a level instead of pulsed, and a frame that ends on the wrong edge.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

  localparam int unsigned TABLE_ADDR_W = 8;
  localparam int unsigned SAMPLE_BITS  = 12;
  localparam int unsigned FRAME_BITS   = 16;
  localparam int unsigned TICK_DIV     = 5;
  localparam int unsigned PERIOD_BITS  = 16;

  // Sample value for entry idx: the address bits repeated from the MSB down
  // until sw bits are filled (for 8/12 this is {idx, idx[7:4]}).
  function automatic logic [31:0] ramp_sample(input int idx, input int aw, input int sw);
    logic [31:0] a;
    logic [31:0] r;
    a = idx;
    r = '0;
    for (int b = 0; b < sw; b++) begin
      r[sw-1-b] = a[aw-1-(b % aw)];
    end
    return r;
  endfunction

endpackage

// File: rtl/wdp_rate_timer.sv
module wdp_rate_timer #(
  parameter int unsigned RATE_W = wdp_pkg::PERIOD_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [RATE_W-1:0] period,
  output logic              trig
);

  logic [RATE_W-1:0] cnt;
  logic [RATE_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + (RATE_W+1)'(1);
  // A period of 0 behaves as 1: a trigger on every clock.
  assign trig     = en && (cnt_next >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (trig) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_next[RATE_W-1:0];
    end
  end

endmodule

// File: rtl/wdp_sample_table.sv
module wdp_sample_table #(
  parameter int unsigned ADDR_W   = wdp_pkg::TABLE_ADDR_W,
  parameter int unsigned SAMPLE_W = wdp_pkg::SAMPLE_BITS
) (
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [SAMPLE_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [SAMPLE_W-1:0] rom [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    assign rom[gi] = SAMPLE_W'(wdp_pkg::ramp_sample(gi, ADDR_W, SAMPLE_W));
  end

  assign rd_data = rom[rd_addr];

endmodule

// File: rtl/wdp_phase_acc.sv
module wdp_phase_acc #(
  parameter int unsigned ADDR_W = wdp_pkg::TABLE_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] addr
);

  // The step is sampled only on the advance cycle (frame start); the sum
  // wraps naturally at the table size.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (advance) begin
      addr <= addr + step;
    end
  end

endmodule

// File: rtl/wdp_serializer.sv
module wdp_serializer #(
  parameter int unsigned FRAME_W = wdp_pkg::FRAME_BITS,
  parameter int unsigned DIV     = wdp_pkg::TICK_DIV
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               cs_n,
  output logic               sclk,
  output logic               sdo,
  output logic               busy
);

  localparam int unsigned HALVES    = 2 * FRAME_W;
  localparam int unsigned HC_W      = $clog2(HALVES);
  localparam int unsigned DV_W      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [HC_W-1:0] HALF_LAST = HC_W'(HALVES - 1);
  localparam logic [DV_W-1:0] DIV_LAST  = DV_W'(DIV - 1);

  logic [FRAME_W-1:0] shreg;
  logic [HC_W-1:0]    half_cnt;
  logic [DV_W-1:0]    div_cnt;
  logic               tick;

  // One-cycle advance pulse every DIV clocks while a frame runs.
  assign tick = busy && (div_cnt == DIV_LAST);
  assign sdo  = shreg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      half_cnt <= '0;
      div_cnt  <= '0;
      busy     <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
    end else if (load) begin
      shreg    <= frame;
      half_cnt <= '0;
      div_cnt  <= '0;
      busy     <= 1'b1;
      cs_n     <= 1'b0;
      sclk     <= 1'b0;
    end else if (busy) begin
      div_cnt <= tick ? '0 : div_cnt + DV_W'(1);
      if (tick) begin
        half_cnt <= half_cnt + HC_W'(1);
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (half_cnt == HALF_LAST) begin
            busy  <= 1'b0;
            cs_n  <= 1'b1;
            shreg <= '0;
          end else begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/wave_dac_player.sv
module wave_dac_player #(
  parameter int unsigned ADDR_W    = wdp_pkg::TABLE_ADDR_W,
  parameter int unsigned SAMPLE_W  = wdp_pkg::SAMPLE_BITS,
  parameter int unsigned FRAME_W   = wdp_pkg::FRAME_BITS,
  parameter int unsigned SHIFT_DIV = wdp_pkg::TICK_DIV,
  parameter int unsigned RATE_W    = wdp_pkg::PERIOD_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] step,
  input  logic [RATE_W-1:0] rate_period,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdo,
  output logic              busy,
  output logic              overrun
);

  localparam int unsigned PAD_W = FRAME_W - SAMPLE_W;

  logic                trig;
  logic                start;
  logic [ADDR_W-1:0]   addr;
  logic [SAMPLE_W-1:0] sample;
  logic [FRAME_W-1:0]  frame;

  wdp_rate_timer #(.RATE_W(RATE_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .period (rate_period),
    .trig   (trig)
  );

  wdp_sample_table #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_table (
    .rd_addr (addr),
    .rd_data (sample)
  );

  // A trigger only starts a frame when the serializer is idle.
  assign start = trig && !busy;

  wdp_phase_acc #(.ADDR_W(ADDR_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .advance (start),
    .step    (step),
    .addr    (addr)
  );

  assign frame = {{PAD_W{1'b0}}, sample};

  wdp_serializer #(.FRAME_W(FRAME_W), .DIV(SHIFT_DIV)) u_ser (
    .clk   (clk),
    .rst   (rst),
    .load  (start),
    .frame (frame),
    .cs_n  (dac_cs_n),
    .sclk  (dac_sclk),
    .sdo   (dac_sdo),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun <= 1'b0;
    end else begin
      overrun <= trig && busy;
    end
  end

endmodule

// File: rtl/wdp_player_checker.sv
module wdp_player_checker #(
  parameter int unsigned FRAME_W = wdp_pkg::FRAME_BITS,
  parameter int unsigned DIV     = wdp_pkg::TICK_DIV
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic sdo,
  input logic busy,
  input logic overrun
);

  localparam int unsigned FRAME_CLKS = 2 * FRAME_W * DIV;

  logic        rst_d = 1'b0;
  logic [31:0] low_cnt;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst || cs_n) begin
      low_cnt <= '0;
    end else begin
      low_cnt <= low_cnt + 32'd1;
    end
  end

  // R1: one edge after reset is seen, the serial pins sit idle
  always @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_idle: assert (cs_n && !sclk && !busy && !overrun)
        else $error("reset state not idle");
    end
  end

  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  a_r4_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n) && !$stable(sdo)) |-> $fell(sclk));

  a_r9_overrun_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(busy));

  a_r10_busy_with_select: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> busy);

  a_r3_frame_window: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> (low_cnt < FRAME_CLKS));

endmodule

bind wave_dac_player wdp_player_checker #(
  .FRAME_W (FRAME_W),
  .DIV     (SHIFT_DIV)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (dac_cs_n),
  .sclk    (dac_sclk),
  .sdo     (dac_sdo),
  .busy    (busy),
  .overrun (overrun)
);

// File: tb/test_wave_dac_player.sv
`timescale 1ns/1ps
module test_wave_dac_player;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [7:0]  step = 8'd0;
  logic [15:0] rate_period = 16'd200;
  logic        dac_cs_n, dac_sclk, dac_sdo, busy, overrun;

  always #2 clk = ~clk;

  wave_dac_player i_wave_dac_player (
    .clk(clk), .rst(rst), .en(en), .step(step), .rate_period(rate_period),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo),
    .busy(busy), .overrun(overrun)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int starts   = 0;
  int ovr_cnt  = 0;
  int model_addr = 0;
  bit done = 1'b0;
  logic [15:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected table entry, from the requirement: {i, i[7:4]}
  function automatic logic [15:0] entry(input int a);
    logic [7:0] i;
    i = a[7:0];
    return {4'b0000, i, i[7:4]};
  endfunction

  task automatic push_frame(input int stp);
    exp_q.push_back(entry(model_addr));
    model_addr = (model_addr + stp) % 256;
  endtask

  // Monitor / scoreboard
  logic        prev_cs = 1'b1;
  logic        prev_sclk = 1'b0;
  logic [15:0] rx;
  int          bits, low_cyc, half_cyc;

  always @(negedge clk) begin
    if (!rst) begin
      if (overrun) ovr_cnt++;
      if (!dac_cs_n) begin
        if (prev_cs) begin
          starts++;
          bits = 0; low_cyc = 0; half_cyc = 0; rx = '0;
          chk(busy == 1'b1, "R10", "busy at frame start", busy, 1);
        end else begin
          half_cyc++;
        end
        low_cyc++;
        if (dac_sclk != prev_sclk) begin
          chk(half_cyc == 5, "R4", "sclk half period", half_cyc, 5);
          half_cyc = 0;
          if (dac_sclk) begin
            rx = {rx[14:0], dac_sdo};
            bits++;
          end
        end
      end else if (!prev_cs) begin
        chk(bits == 16, "R4", "rising edges per frame", bits, 16);
        chk(low_cyc == 160, "R3", "select low clocks", low_cyc, 160);
        chk(!busy && !dac_sclk, "R10", "busy/sclk at frame end", busy, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected frame", rx, -1);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rx == e, "R3 R5 R6", "frame word", rx, e);
        end
      end
      prev_cs   = dac_cs_n;
      prev_sclk = dac_sclk;
    end
  end

  task automatic wait_starts(input int target);
    while (starts < target) @(negedge clk);
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (!dac_cs_n || busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frames(input int stp, input int per, input int n);
    int base;
    base = starts;
    step = 8'(stp);
    rate_period = 16'(per);
    for (int k = 0; k < n; k++) push_frame(stp);
    en = 1'b1;
    wait_starts(base + n);
    en = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R6", "frames outstanding", exp_q.size(), 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    int base;
    int ovr0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(dac_cs_n == 1'b1, "R1", "cs_n in reset", dac_cs_n, 1);
    chk(dac_sclk == 1'b0, "R1", "sclk in reset", dac_sclk, 0);
    chk(dac_sdo == 1'b0 && busy == 1'b0 && overrun == 1'b0, "R1", "sdo/busy/overrun in reset",
        dac_sdo + busy + overrun, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R2 first-frame latency and R6 first entry 0
    step = 8'd1;
    rate_period = 16'd200;
    for (int k = 0; k < 4; k++) push_frame(1);
    base = starts;
    en = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (dac_cs_n);
    chk(lat == 200, "R2", "first frame latency", lat, 200);
    wait_starts(base + 4);
    en = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R6", "frames outstanding", exp_q.size(), 0);

    // R6 larger step
    run_frames(10, 180, 4);

    // R7 wrap past 255
    run_frames(200, 170, 4);

    // R8 step changed mid-frame
    base = starts;
    step = 8'd3;
    rate_period = 16'd200;
    push_frame(3);  // in-flight frame uses old step for the next address
    push_frame(7);
    push_frame(7);
    push_frame(7);
    en = 1'b1;
    wait_starts(base + 1);
    repeat (20) @(negedge clk);
    step = 8'd7;
    wait_starts(base + 4);
    en = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R8", "frames outstanding", exp_q.size(), 0);

    // R9 trigger period shorter than a frame
    ovr0 = ovr_cnt;
    run_frames(5, 100, 3);
    chk(ovr_cnt - ovr0 >= 1, "R9", "overrun pulses seen", ovr_cnt - ovr0, 1);

    // R2 disabled: no frames
    base = starts;
    repeat (800) @(negedge clk);
    chk(starts == base, "R2", "frames while disabled", starts - base, 0);
    chk(dac_cs_n == 1'b1 && !dac_sclk, "R4", "idle lines while disabled", dac_sclk, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule